// File: doc/BRIEF.md
# One-Time-Programmable Word Memory with Parallel Read/Program Pins

This block models a word-wide one-time-programmable memory behind a parallel pin interface: an address bus, three active-low strobes (chip select, output gate and program pulse) and two digital flags that stand in for analog levels. One flag marks the high programming supply and the other marks the identity-code level on an address pin. Every control, address and data input passes through a synchroniser of `SYNC_STAGES` flops. The operating mode is then decoded from the synchronised values with no further clocking.

Reads return the addressed word. Programming can only clear bits, so the stored word becomes the old word ANDed with the presented data. An identity mode returns fixed codes. The data bus is split into a `dout` bus and a `dout_en` qualifier, where a real part would use a tristate pin. The pins are plain level-sensitive controls with no valid/ready handshake. The host owns the timing and holds inputs steady for at least `SYNC_STAGES` clocks.

Top module: `otp_word_mem`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_hi`=0 and `sig_mode`=0, `dout_en` is 1 and `dout` carries the word at `addr`. The output reflects an input change after exactly `SYNC_STAGES` rising clock edges.
- R2: With `ce_n`=1 and `vpp_hi`=0 (standby), `dout_en` is 0 for either value of `oe_n`.
- R3: With `ce_n`=0 and `oe_n`=1 (output disable), `dout_en` is 0.
- R4: With `vpp_hi`=1 and `ce_n`=0, a low pulse on `pgm_n` writes `din` to the word at `addr` when `pgm_n` rises. `dout_en` is 0 while the pulse is low.
- R5: A write stores the old word ANDed with `din`. A bit that is 0 never returns to 1 through programming.
- R6: After reset every word of the array reads as all ones.
- R7: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1 (verify), `dout_en` is 1 and `dout` carries the addressed word.
- R8: With `vpp_hi`=1 and `ce_n`=1 (program inhibit), `dout_en` is 0 and pulses on `pgm_n` leave the array unchanged.
- R9: With `sig_mode`=1, `vpp_hi`=0, `ce_n`=0, `oe_n`=0 and `pgm_n`=1, `dout` carries 16'h0020 when `addr[0]`=0 and 16'h008C when `addr[0]`=1. Bits 15 to 8 are zero.
- R10: Any other combination, including `ce_n`=0, `oe_n`=0 and `pgm_n`=0 with `vpp_hi`=0, acts as output disable. `dout_en` is 0 and a `pgm_n` pulse writes nothing.
- R11: Whenever `dout_en` is 0, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array to ones |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply present |
| sig_mode | input | 1 | Identity-code mode request |
| din | input | DATA_W | Word to program |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with `ADDR_W`=4 and `SYNC_STAGES`=3. A 16-word array lets the reset-erased state be swept over every address. The deeper synchroniser makes the exact latency window observable: the output must stay quiet for two edges and switch on the third. Repeated programming of one word shows that bits only clear. Program pulses in inhibit mode and in the undefined combination are followed by read-back to prove that the array was left untouched.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    MODE_DISABLE = 3'd0,
    MODE_READ    = 3'd1,
    MODE_STANDBY = 3'd2,
    MODE_PROG    = 3'd3,
    MODE_VERIFY  = 3'd4,
    MODE_INHIBIT = 3'd5,
    MODE_SIG     = 3'd6
  } mode_e;

  localparam logic [7:0] MAKER_CODE = 8'h20;
  localparam logic [7:0] PART_CODE  = 8'h8C;

  // control vector bit positions after synchronisation
  localparam int CTL_CE  = 0;
  localparam int CTL_OE  = 1;
  localparam int CTL_PGM = 2;
  localparam int CTL_VPP = 3;
  localparam int CTL_SIG = 4;
  localparam int CTL_W   = 5;
endpackage

// File: rtl/otp_sync.sv
module otp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[s] <= RST_VAL;
      end else begin
        if (s == 0) stage[s] <= d;
        else        stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  vpp_hi,
  input  logic  sig_mode,
  output mode_e mode
);
  always_comb begin
    mode = MODE_DISABLE;
    if (ce_n) begin
      mode = vpp_hi ? MODE_INHIBIT : MODE_STANDBY;
    end else if (vpp_hi) begin
      if (!pgm_n)     mode = MODE_PROG;
      else if (!oe_n) mode = MODE_VERIFY;
      else            mode = MODE_DISABLE;
    end else begin
      if (!oe_n && pgm_n) mode = sig_mode ? MODE_SIG : MODE_READ;
      else                mode = MODE_DISABLE;
    end
  end
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[wr_addr] <= cells[wr_addr] & wr_data;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/otp_out_mux.sv
module otp_out_mux
  import otp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  mode_e             mode,
  input  logic [DATA_W-1:0] word,
  input  logic              sel_part,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int PAD_W = DATA_W - 8;

  always_comb begin
    dout    = '0;
    dout_en = 1'b0;
    unique case (mode)
      MODE_READ, MODE_VERIFY: begin
        dout    = word;
        dout_en = 1'b1;
      end
      MODE_SIG: begin
        dout    = {{PAD_W{1'b0}}, (sel_part ? PART_CODE : MAKER_CODE)};
        dout_en = 1'b1;
      end
      default: begin
        dout    = '0;
        dout_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
  import otp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              sig_mode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam logic [CTL_W-1:0] CTL_IDLE = CTL_W'(5'b00111);

  logic [CTL_W-1:0]  ctl_raw, ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              ce_s, oe_s, pgm_s, vpp_s, sig_s;
  mode_e             mode, mode_q;
  logic              wr_en;
  logic [DATA_W-1:0] word;

  assign ctl_raw = {sig_mode, vpp_hi, pgm_n, oe_n, ce_n};

  otp_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));
  otp_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s));
  otp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s));

  assign ce_s  = ctl_s[CTL_CE];
  assign oe_s  = ctl_s[CTL_OE];
  assign pgm_s = ctl_s[CTL_PGM];
  assign vpp_s = ctl_s[CTL_VPP];
  assign sig_s = ctl_s[CTL_SIG];

  otp_mode_dec u_dec (
    .ce_n(ce_s), .oe_n(oe_s), .pgm_n(pgm_s), .vpp_hi(vpp_s),
    .sig_mode(sig_s), .mode(mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_DISABLE;
    else        mode_q <= mode;
  end

  // commit on the rising edge of the strobe that closes a program pulse
  assign wr_en = (mode_q == MODE_PROG) && pgm_s && vpp_s && !ce_s;

  otp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr_s),
    .wr_data(din_s), .rd_addr(addr_s), .rd_data(word));

  otp_out_mux #(.DATA_W(DATA_W)) u_out (
    .mode(mode), .word(word), .sel_part(addr_s[0]),
    .dout(dout), .dout_en(dout_en));
endmodule

// File: rtl/otp_word_mem_chk.sv
module otp_word_mem_chk
  import otp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_s,
  input logic              oe_s,
  input logic              vpp_s,
  input logic              wr_en,
  input mode_e             mode,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  // R1, R3: drive only with both selects low
  a_r1_drive_needs_selects: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_s && !oe_s));

  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_s |-> !dout_en);

  a_r4_pulse_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PROG) |-> !dout_en);

  a_r8_inhibit_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_s && ce_s) |-> !wr_en);

  a_r9_sig_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SIG) |-> (dout_en && dout[DATA_W-1:8] == '0));

  a_r10_no_write_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_s |-> !wr_en);

  a_r11_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
endmodule

bind otp_word_mem otp_word_mem_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .oe_s(oe_s), .vpp_s(vpp_s),
  .wr_en(wr_en), .mode(mode), .dout(dout), .dout_en(dout_en));

// File: tb/otp_word_mem_tb.sv
module otp_word_mem_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 16;
  localparam int SYNC_STAGES = 3;
  localparam int DEPTH       = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, sig_mode = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              dout_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .sig_mode(sig_mode), .din(din), .dout(dout), .dout_en(dout_en));

  task automatic check(input string req, input logic [DATA_W:0] act, input logic [DATA_W:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SYNC_STAGES + 1) @(negedge clk);
  endtask

  task automatic pins(input logic c, input logic o, input logic p, input logic v,
                      input logic s, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; sig_mode = s; addr = a; din = d;
    settle();
  endtask

  task automatic t_reset();
    check("R11 reset bus", {dout_en, dout}, '0);
    for (int a = 0; a < DEPTH; a++) begin
      pins(0, 0, 1, 0, 0, a[ADDR_W-1:0], '0);
      check("R6 erased word", {dout_en, dout}, {1'b1, 16'hFFFF});
    end
  endtask

  task automatic t_standby();
    pins(1, 0, 1, 0, 0, 4'd2, '0);
    check("R2 standby oe low", {dout_en, dout}, '0);
    pins(1, 1, 1, 0, 0, 4'd2, '0);
    check("R2 standby oe high", {dout_en, dout}, '0);
  endtask

  task automatic t_disable();
    pins(0, 1, 1, 0, 0, 4'd5, '0);
    check("R3 output disable", {dout_en, dout}, '0);
  endtask

  task automatic program_word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    pins(0, 1, 1, 1, 0, a, d);
    pins(0, 1, 0, 1, 0, a, d);
    check("R4 no drive in pulse", {1'b0, dout_en}, '0);
    pins(0, 1, 1, 1, 0, a, d);
    model[a] = model[a] & d;
  endtask

  task automatic t_program();
    program_word(4'd3, 16'hA5C3);
    pins(0, 0, 1, 1, 0, 4'd3, '0);
    check("R7 verify word", {dout_en, dout}, {1'b1, model[3]});
    check("R4 written value", {1'b0, model[3]}, {1'b0, 16'hA5C3});
    pins(0, 0, 1, 0, 0, 4'd3, '0);
    check("R1 read programmed", {dout_en, dout}, {1'b1, 16'hA5C3});
    pins(0, 0, 1, 0, 0, 4'd4, '0);
    check("R1 neighbour untouched", {dout_en, dout}, {1'b1, 16'hFFFF});
  endtask

  task automatic t_and();
    program_word(4'd3, 16'hFF0F);
    pins(0, 0, 1, 0, 0, 4'd3, '0);
    check("R5 and merge", {dout_en, dout}, {1'b1, 16'hA503});
    program_word(4'd3, 16'hFFFF);
    pins(0, 0, 1, 0, 0, 4'd3, '0);
    check("R5 zero stays zero", {dout_en, dout}, {1'b1, 16'hA503});
  endtask

  task automatic t_inhibit();
    pins(1, 0, 1, 1, 0, 4'd7, 16'h0000);
    check("R8 inhibit quiet", {dout_en, dout}, '0);
    pins(1, 0, 0, 1, 0, 4'd7, 16'h0000);
    pins(1, 0, 1, 1, 0, 4'd7, 16'h0000);
    pins(0, 0, 1, 0, 0, 4'd7, '0);
    check("R8 inhibit no write", {dout_en, dout}, {1'b1, 16'hFFFF});
  endtask

  task automatic t_undefined();
    pins(0, 0, 0, 0, 0, 4'd9, 16'h0000);
    check("R10 undefined quiet", {dout_en, dout}, '0);
    pins(0, 0, 1, 0, 0, 4'd9, 16'h0000);
    check("R10 undefined no write", {dout_en, dout}, {1'b1, 16'hFFFF});
  endtask

  task automatic t_signature();
    pins(0, 0, 1, 0, 1, 4'd0, '0);
    check("R9 maker code", {dout_en, dout}, {1'b1, 16'h0020});
    pins(0, 0, 1, 0, 1, 4'd1, '0);
    check("R9 part code", {dout_en, dout}, {1'b1, 16'h008C});
    pins(0, 0, 1, 0, 1, 4'd2, '0);
    check("R9 a0 only", {dout_en, dout}, {1'b1, 16'h0020});
  endtask

  task automatic t_latency();
    pins(0, 1, 1, 0, 0, 4'd3, '0);
    oe_n = 1'b0;
    repeat (SYNC_STAGES - 1) @(posedge clk);
    @(negedge clk);
    check("R1 before latency", {1'b0, dout_en}, '0);
    @(posedge clk);
    @(negedge clk);
    check("R1 at latency", {dout_en, dout}, {1'b1, 16'hA503});
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_standby();
    t_disable();
    t_program();
    t_and();
    t_inhibit();
    t_undefined();
    t_signature();
    t_latency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule